// File: doc/BRIEF.md
# DMA Engine Command and Status Register Slave

This block is the register-side front end of a plain memory-to-memory DMA engine. A command master writes the source, destination and byte count into 32-bit registers over a write channel with valid/ready and per-byte strobes. It then issues a control word that starts the transfer. The block holds those registers and decodes the control word into start, clear, interrupt-enable and abort commands. It keeps busy, done, abort and error flags and presents them in a status word that lags the internal state by one cycle.

The real data mover is replaced by a timer. The timer accounts for four bytes per cycle and raises a one-cycle completion pulse when the count runs out. An abort is a special control write: only the most significant byte lane is enabled, and that byte carries a fixed key. It winds the transfer down after a fixed number of cycles. A start with a source or destination address that is not word aligned is refused with an error. The outputs expose the captured addresses, the length, the QoS and protection fields and an interrupt line.

Top module: `dma_ctl_slave`

## Requirements
- R1: After reset the status word is zero, the completion pulse and interrupt are low, the write channel is ready, and the source, destination and length outputs are zero.
- R2: Writes to byte offsets 0x08/0x0C (source low/high), 0x10/0x14 (destination low/high) and 0x18/0x1C (length low/high) update only the byte lanes whose strobe is set. Address bits 1:0 are ignored, and offset 0x04 stores nothing.
- R3: A write to offset 0x00 with strobe bit 0 set and data bit 0 set starts a transfer when idle. It captures QoS from data bits 19:16 and protection from bits 22:20. The write channel is not ready in the single cycle after the accepting edge and is ready again one cycle later.
- R4: The status word carries busy in bit 0, done in bit 1, abort in bit 3 and error in bit 4, with all other bits zero. Each bit shows the internal flag one cycle late, so busy is still 0 just after the start is accepted and is 1 one cycle later.
- R5: With valid alignment, the completion pulse comes exactly ceil(length/4)+1 cycles after the start is accepted. A zero length completes one cycle after acceptance.
- R6: A normal completion gives a single-cycle pulse and sets done. Status busy is still 1 during the pulse and drops in the next cycle.
- R7: An abort is a write to offset 0x00 with strobe 0x8 and key 0x6D in bits 31:24, accepted while running. It gives the completion pulse exactly two cycles after acceptance, sets the abort flag and leaves done clear. A wrong key, or an abort while idle, has no effect.
- R8: A start with source or destination bits 1:0 non-zero completes one cycle after acceptance with the error flag set and done clear. Error is 0 in the first status cycle that shows busy, and it only rises in a cycle that follows a busy status.
- R9: A control write with strobe bit 0 clears the abort flag when data bit 3 is set and clears the error flag when data bit 4 is set. The cleared flag reads 0 in the status word two cycles after the accepting edge.
- R10: Every control write with strobe bit 0 loads the interrupt enable from data bit 2. Any completion while it is enabled raises the interrupt. Data bit 1 set clears a pending interrupt.
- R11: While a transfer is in progress, writes to the address and length registers and further start commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write channel ready |
| wr_addr_i | input | ADDR_W | Byte offset of the register |
| wr_data_i | input | DATA_W | Write data |
| wr_strb_i | input | DATA_W/8 | Byte lane enables |
| status_o | output | DATA_W | Registered status word |
| xfer_done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Pending interrupt |
| src_addr_o | output | 2*DATA_W | Captured source address |
| dst_addr_o | output | 2*DATA_W | Captured destination address |
| xfer_len_o | output | 2*DATA_W | Captured length in bytes |
| qos_o | output | 4 | QoS of the current transfer |
| prot_o | output | 3 | Protection of the current transfer |

## Verification
The hardest case to reach from the ports is the abort path. The abort has to arrive while the timer is in its running state, and not in the cycle when the start is still being taken, since the channel is not ready then. The stimulus starts a long transfer, lets a few cycles pass, and issues the keyed top-byte write. It then measures the pulse from a free-running edge counter. A length sweep from 0 to 33 bytes covers every remainder of the divide-by-four rounding and the zero-length shortcut.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    // status word bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_DONE  = 1;
    localparam int ST_ABORT = 3;
    localparam int ST_ERR   = 4;

    // control word command bits (byte lane 0)
    localparam int CB_START     = 0;
    localparam int CB_CLR_IRQ   = 1;
    localparam int CB_IRQ_EN    = 2;
    localparam int CB_CLR_ABORT = 3;
    localparam int CB_CLR_ERR   = 4;

    // control word field positions
    localparam int QOS_LSB  = 16;
    localparam int PROT_LSB = 20;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_LOAD = 2'd1,
        MV_RUN  = 2'd2,
        MV_STOP = 2'd3
    } mv_state_e;

    typedef struct packed {
        logic       start;
        logic       clr_irq;
        logic       irq_en_wr;
        logic       irq_en_val;
        logic       clr_abort;
        logic       clr_err;
        logic       abort;
        logic [3:0] qos;
        logic [2:0] prot;
    } cmd_t;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_ctl_pkg::*;
#(
    parameter int         ADDR_W    = 5,
    parameter int         DATA_W    = 32,
    parameter int         NREG      = 6,
    parameter logic [7:0] ABORT_KEY = 8'h6D,
    localparam int        STRB_W    = DATA_W / 8
) (
    input  logic              fire_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [STRB_W-1:0] strb_i,
    input  logic              busy_i,
    output cmd_t              cmd_o,
    output logic [NREG-1:0]   reg_we_o
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [STRB_W-1:0] TOP_LANE = {1'b1, {(STRB_W-1){1'b0}}};

    logic [IDX_W-1:0] idx;
    logic             ctl_hit;

    assign idx     = addr_i[ADDR_W-1:2];
    assign ctl_hit = fire_i && (idx == '0);

    always_comb begin
        cmd_o      = '0;
        cmd_o.qos  = data_i[QOS_LSB +: 4];
        cmd_o.prot = data_i[PROT_LSB +: 3];
        if (ctl_hit && strb_i[0]) begin
            cmd_o.start      = data_i[CB_START] && !busy_i;
            cmd_o.clr_irq    = data_i[CB_CLR_IRQ];
            cmd_o.irq_en_wr  = 1'b1;
            cmd_o.irq_en_val = data_i[CB_IRQ_EN];
            cmd_o.clr_abort  = data_i[CB_CLR_ABORT];
            cmd_o.clr_err    = data_i[CB_CLR_ERR];
        end
        cmd_o.abort = ctl_hit && (strb_i == TOP_LANE) &&
                      (data_i[DATA_W-1 -: 8] == ABORT_KEY) && busy_i;
    end

    // register word r sits at word index r+2
    for (genvar r = 0; r < NREG; r++) begin : g_we
        assign reg_we_o[r] = fire_i && !busy_i && (idx == IDX_W'(r + 2));
    end

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
    parameter int  DATA_W = 32,
    parameter int  NREG   = 6,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NREG-1:0]             we_i,
    input  logic [DATA_W-1:0]           data_i,
    input  logic [STRB_W-1:0]           strb_i,
    output logic [NREG-1:0][DATA_W-1:0] words_o
);
    logic [NREG-1:0][DATA_W-1:0] words_d, words_q;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        for (genvar b = 0; b < STRB_W; b++) begin : g_lane
            assign words_d[r][b*8 +: 8] = (we_i[r] && strb_i[b]) ?
                                          data_i[b*8 +: 8] : words_q[r][b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) words_q <= '0;
        else        words_q <= words_d;
    end

    assign words_o = words_q;

endmodule

// File: rtl/dma_ctl_mover.sv
module dma_ctl_mover
    import dma_ctl_pkg::*;
#(
    parameter int  LEN_W     = 64,
    parameter int  ABORT_LAT = 2,
    localparam int CNT_W     = LEN_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd_i,
    input  logic             misalign_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             loading_o,
    output logic             pulse_o,
    output logic             irq_o,
    output logic             done_o,
    output logic             abort_o,
    output logic             err_o,
    output logic [3:0]       qos_o,
    output logic [2:0]       prot_o
);
    typedef struct packed {
        mv_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             abort;
        logic             err;
        logic             irq_en;
        logic             irq_pend;
        logic             pulse;
        logic [3:0]       qos;
        logic [2:0]       prot;
    } mv_t;

    mv_t              d, q;
    logic             fin;
    logic [CNT_W-1:0] beats;

    // word beats, rounding a partial last word up
    assign beats = CNT_W'(len_i >> 2) + CNT_W'(|len_i[1:0]);

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        fin     = 1'b0;
        if (cmd_i.clr_irq)   d.irq_pend = 1'b0;
        if (cmd_i.clr_abort) d.abort    = 1'b0;
        if (cmd_i.clr_err)   d.err      = 1'b0;
        if (cmd_i.irq_en_wr) d.irq_en   = cmd_i.irq_en_val;
        unique case (q.st)
            MV_IDLE: begin
                if (cmd_i.start) begin
                    d.st   = MV_LOAD;
                    d.done = 1'b0;
                    d.qos  = cmd_i.qos;
                    d.prot = cmd_i.prot;
                end
            end
            MV_LOAD: begin
                if (misalign_i) begin
                    fin   = 1'b1;
                    d.err = 1'b1;
                end else if (beats == '0) begin
                    fin    = 1'b1;
                    d.done = 1'b1;
                end else begin
                    d.st  = MV_RUN;
                    d.cnt = beats;
                end
            end
            MV_RUN: begin
                if (cmd_i.abort) begin
                    d.st  = MV_STOP;
                    d.cnt = CNT_W'(ABORT_LAT);
                end else if (q.cnt == CNT_W'(1)) begin
                    fin    = 1'b1;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            MV_STOP: begin
                if (q.cnt <= CNT_W'(1)) begin
                    fin     = 1'b1;
                    d.abort = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.st = MV_IDLE;
        endcase
        if (fin) begin
            d.st    = MV_IDLE;
            d.pulse = 1'b1;
            if (d.irq_en) d.irq_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o    = (q.st != MV_IDLE);
    assign loading_o = (q.st == MV_LOAD);
    assign pulse_o   = q.pulse;
    assign irq_o     = q.irq_pend;
    assign done_o    = q.done;
    assign abort_o   = q.abort;
    assign err_o     = q.err;
    assign qos_o     = q.qos;
    assign prot_o    = q.prot;

endmodule

// File: rtl/dma_ctl_slave.sv
module dma_ctl_slave
    import dma_ctl_pkg::*;
#(
    parameter int         ADDR_W    = 5,
    parameter int         DATA_W    = 32,
    parameter int         ABORT_LAT = 2,
    parameter logic [7:0] ABORT_KEY = 8'h6D,
    localparam int        STRB_W    = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid_i,
    output logic                wr_ready_o,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [STRB_W-1:0]   wr_strb_i,
    output logic [DATA_W-1:0]   status_o,
    output logic                xfer_done_o,
    output logic                irq_o,
    output logic [2*DATA_W-1:0] src_addr_o,
    output logic [2*DATA_W-1:0] dst_addr_o,
    output logic [2*DATA_W-1:0] xfer_len_o,
    output logic [3:0]          qos_o,
    output logic [2:0]          prot_o
);
    localparam int NREG  = 6;
    localparam int LEN_W = 2 * DATA_W;

    logic                        fire, busy, loading;
    logic                        f_done, f_abort, f_err;
    cmd_t                        cmd;
    logic [NREG-1:0]             reg_we;
    logic [NREG-1:0][DATA_W-1:0] words;
    logic                        misalign;
    logic [DATA_W-1:0]           status_d, status_q;

    assign wr_ready_o = !loading;
    assign fire       = wr_valid_i && wr_ready_o;

    dma_ctl_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .ABORT_KEY(ABORT_KEY)
    ) u_decode (
        .fire_i(fire), .addr_i(wr_addr_i), .data_i(wr_data_i), .strb_i(wr_strb_i),
        .busy_i(busy), .cmd_o(cmd), .reg_we_o(reg_we)
    );

    dma_ctl_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .data_i(wr_data_i),
        .strb_i(wr_strb_i), .words_o(words)
    );

    assign src_addr_o = {words[1], words[0]};
    assign dst_addr_o = {words[3], words[2]};
    assign xfer_len_o = {words[5], words[4]};
    assign misalign   = (|words[0][1:0]) || (|words[2][1:0]);

    dma_ctl_mover #(.LEN_W(LEN_W), .ABORT_LAT(ABORT_LAT)) u_mover (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .misalign_i(misalign),
        .len_i(xfer_len_o), .busy_o(busy), .loading_o(loading),
        .pulse_o(xfer_done_o), .irq_o(irq_o), .done_o(f_done),
        .abort_o(f_abort), .err_o(f_err), .qos_o(qos_o), .prot_o(prot_o)
    );

    always_comb begin
        status_d           = '0;
        status_d[ST_BUSY]  = busy;
        status_d[ST_DONE]  = f_done;
        status_d[ST_ABORT] = f_abort;
        status_d[ST_ERR]   = f_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;

endmodule

// File: rtl/dma_ctl_slave_chk.sv
module dma_ctl_slave_chk #(
    parameter int  ADDR_W = 5,
    parameter int  DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid_i,
    input logic              wr_ready_o,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [STRB_W-1:0] wr_strb_i,
    input logic [DATA_W-1:0] status_o,
    input logic              xfer_done_o,
    input logic              busy
);
    logic ctl_acc, start_acc, clr_err_acc;
    assign ctl_acc     = wr_valid_i && wr_ready_o && (wr_addr_i[ADDR_W-1:2] == '0) && wr_strb_i[0];
    assign start_acc   = ctl_acc && wr_data_i[0] && !busy;
    assign clr_err_acc = ctl_acc && wr_data_i[4];

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |=> !xfer_done_o);
    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |-> status_o[0] ##1 !status_o[0]);
    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[DATA_W-1:5] == '0) && !status_o[2]);
    // R3
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> !wr_ready_o ##1 wr_ready_o);
    // R8
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[4]) |-> $past(status_o[0]) && !status_o[1]);
    // R7
    abort_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[3]) |-> !status_o[1] && !status_o[0]);
    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err_acc |=> ##1 !status_o[4]);

endmodule

bind dma_ctl_slave dma_ctl_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_strb_i(wr_strb_i),
    .status_o(status_o), .xfer_done_o(xfer_done_o), .busy(busy)
);

// File: tb/dma_ctl_slave_tb.sv
module dma_ctl_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic        wr_ready_o;
    logic [4:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  wr_strb_i = '0;
    logic [31:0] status_o;
    logic        xfer_done_o, irq_o;
    logic [63:0] src_addr_o, dst_addr_o, xfer_len_o;
    logic [3:0]  qos_o;
    logic [2:0]  prot_o;

    int n_chk = 0, n_bad = 0, ncyc = 0, k, cyc;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) ncyc <= ncyc + 1;

    dma_ctl_slave u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] dt, input logic [3:0] s);
        bit acc;
        wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = dt; wr_strb_i = s;
        acc = wr_ready_o;
        @(negedge clk);
        while (!acc) begin acc = wr_ready_o; @(negedge clk); end
        wr_valid_i = 1'b0; wr_strb_i = '0;
    endtask

    task automatic wait_pulse(input int from);
        while (!xfer_done_o && (ncyc - from) < 5000) @(negedge clk);
        cyc = ncyc - from;
    endtask

    task automatic go(input logic [31:0] ctl);
        wr(5'h00, ctl, 4'hF);
        k = ncyc;
        chk("R3 ready low after start", wr_ready_o, 0);
        chk("R4 busy not yet visible", status_o[0], 0);
        @(negedge clk);
        chk("R4 busy visible one cycle later", status_o[0], 1);
        chk("R8 error low as busy appears", status_o[4], 0);
        wait_pulse(k);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk("R1 status", status_o, 0);
        chk("R1 ready", wr_ready_o, 1);
        chk("R1 pulse", xfer_done_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 regs", src_addr_o | dst_addr_o | xfer_len_o, 0);

        // R2 register writes and lanes
        wr(5'h08, 32'h1122_3344, 4'hF);
        wr(5'h0C, 32'h5566_7788, 4'hF);
        wr(5'h10, 32'h99AA_BBCC, 4'hF);
        wr(5'h14, 32'h0102_0304, 4'hF);
        chk("R2 src", src_addr_o, 64'h5566_7788_1122_3344);
        chk("R2 dst", dst_addr_o, 64'h0102_0304_99AA_BBCC);
        wr(5'h04, 32'hFFFF_FFFF, 4'hF);
        chk("R2 offset 4 inert", src_addr_o ^ dst_addr_o ^ xfer_len_o,
            64'h5566_7788_1122_3344 ^ 64'h0102_0304_99AA_BBCC);
        wr(5'h1B, 32'h1234_5678, 4'b0101);
        chk("R2 strobe lanes", xfer_len_o, 64'h0000_0000_0034_0078);
        wr(5'h1C, 32'h0, 4'hF);
        wr(5'h08, 32'h1000, 4'hF); wr(5'h0C, 0, 4'hF);
        wr(5'h10, 32'h2000, 4'hF); wr(5'h14, 0, 4'hF);

        // R5 R6 length sweep
        for (int len = 0; len <= 33; len++) begin
            wr(5'h18, len, 4'hF);
            go(32'h1);
            chk("R5 completion latency", cyc, (len + 3) / 4 + 1);
            @(negedge clk);
            chk("R6 pulse single", xfer_done_o, 0);
            chk("R6 status done idle", status_o, 32'h2);
        end

        // R3 QoS and protection capture
        wr(5'h18, 8, 4'hF);
        go(32'h005A_0001);
        chk("R3 qos", qos_o, 4'hA);
        chk("R3 prot", prot_o, 3'h5);
        @(negedge clk);

        // R7 abort
        wr(5'h18, 400, 4'hF);
        wr(5'h00, 32'h1, 4'hF);
        repeat (5) @(negedge clk);
        wr(5'h00, 32'h6D00_0000, 4'h8);
        k = ncyc;
        wait_pulse(k);
        chk("R7 abort latency", cyc, 2);
        @(negedge clk);
        chk("R7 abort status", status_o, 32'h8);
        // R9 clear abort
        wr(5'h00, 32'h8, 4'hF);
        chk("R9 abort still shown", status_o[3], 1);
        @(negedge clk);
        chk("R9 abort cleared", status_o[3], 0);
        // R7 wrong key ignored
        wr(5'h18, 40, 4'hF);
        wr(5'h00, 32'h1, 4'hF);
        k = ncyc;
        repeat (3) @(negedge clk);
        wr(5'h00, 32'h6C00_0000, 4'h8);
        wait_pulse(k);
        chk("R7 wrong key ignored", cyc, 11);
        @(negedge clk);
        chk("R7 wrong key status", status_o, 32'h2);
        // R7 abort while idle
        wr(5'h00, 32'h6D00_0000, 4'h8);
        repeat (2) @(negedge clk);
        chk("R7 idle abort ignored", status_o, 32'h2);

        // R8 misaligned source then destination
        wr(5'h08, 32'h1002, 4'hF);
        go(32'h1);
        chk("R8 error latency", cyc, 1);
        @(negedge clk);
        chk("R8 error status", status_o, 32'h10);
        wr(5'h00, 32'h10, 4'hF);
        chk("R9 error still shown", status_o[4], 1);
        @(negedge clk);
        chk("R9 error cleared", status_o[4], 0);
        wr(5'h08, 32'h1000, 4'hF);
        wr(5'h10, 32'h2001, 4'hF);
        go(32'h1);
        chk("R8 dst error latency", cyc, 1);
        @(negedge clk);
        chk("R8 dst error status", status_o, 32'h10);
        wr(5'h00, 32'h10, 4'hF);
        wr(5'h10, 32'h2000, 4'hF);

        // R10 interrupt
        wr(5'h18, 8, 4'hF);
        go(32'h5);
        chk("R10 irq on completion", irq_o, 1);
        @(negedge clk);
        wr(5'h00, 32'h2, 4'hF);
        chk("R10 irq cleared", irq_o, 0);
        go(32'h1);
        chk("R10 irq disabled", irq_o, 0);
        @(negedge clk);

        // R11 writes while busy
        wr(5'h18, 80, 4'hF);
        wr(5'h00, 32'h1, 4'hF);
        k = ncyc;
        wr(5'h08, 32'hDEAD_0000, 4'hF);
        wr(5'h18, 32'h4, 4'hF);
        wr(5'h00, 32'h1, 4'hF);
        chk("R11 src held", src_addr_o, 64'h1000);
        chk("R11 len held", xfer_len_o, 64'd80);
        wait_pulse(k);
        chk("R11 restart ignored", cyc, 21);
        repeat (3) @(negedge clk);
        chk("R11 stays idle", status_o, 32'h2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule